// File: doc/BRIEF.md
# Block Move Engine with Direction Control

This engine moves a block of words inside one memory. A single start pulse loads a source pointer, a destination pointer, an element count and a direction bit. The engine then walks the block one element at a time. For each element it reads the word at the source pointer in one cycle and writes it to the destination pointer in the next. After each write, both pointers step by one and the count drops by one. When the count reaches zero the engine raises a one-cycle done pulse and returns to idle.

The direction bit chooses the stepping for both pointers together. When it is clear, both pointers climb toward higher addresses. When it is set, both pointers fall toward lower addresses. Pointer arithmetic wraps around the address space. When the block ends, the pointer and count registers keep their final values on the outputs until the next start, so the caller can continue a chained move from where this one stopped.

The memory port is a single synchronous port. A read presented in one cycle returns its data on `mem_rdata_i` in the following cycle.

Top module: `blkmove_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are low, and `cnt_o`, `src_ptr_o` and `dst_ptr_o` read zero.
- R2: Each element takes two cycles. In the first, `mem_rd_o` is high with `mem_addr_o` equal to the source pointer. In the second, `mem_wr_o` is high with `mem_addr_o` equal to the destination pointer and `mem_wdata_o` equal to the word returned by that read. Read and write are never high in the same cycle.
- R3: The count register drops by exactly one after each element write. A transfer started with count N performs exactly N writes and ends with `cnt_o` equal to 0.
- R4: With the direction input at 0, both pointers increase by one after each element.
- R5: With the direction input at 1, both pointers decrease by one after each element.
- R6: Pointers wrap modulo 2^AW in both directions.
- R7: A start with count 0 makes no memory access and raises `done_o` in the cycle after the accepting clock edge.
- R8: `busy_o` is high from the cycle after the accepting edge through the cycle in which `done_o` is high. `done_o` is a single-cycle pulse that arrives 2N+1 cycles after the accepting edge.
- R9: When `done_o` is high, each pointer output equals its start value moved N steps in the chosen direction. The outputs hold these values while the engine stays idle.
- R10: A start pulse that arrives while `busy_o` is high is ignored and does not change the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request; accepted only while idle |
| src_i | input | AW | Initial source pointer |
| dst_i | input | AW | Initial destination pointer |
| cnt_i | input | CW | Number of elements to move |
| dir_down_i | input | 1 | 0 = step up, 1 = step down |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Memory read enable |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read |
| mem_wr_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DW | Write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_ptr_o | output | AW | Current source pointer |
| dst_ptr_o | output | AW | Current destination pointer |
| cnt_o | output | CW | Remaining element count |

## Verification
The bench targets a zero count, where a faulty engine would touch memory or decrement the count below zero and run for 2^CW elements. It also crosses the top and bottom of the address space in both directions, where a design that saturated or mis-sized its pointers would write the wrong cells. It runs overlapping downward copies, where a swapped read/write order or a stale read word would corrupt data. Finally, it pulses start again in mid-transfer, where a design that reloaded its registers would end with the wrong pointers or the wrong number of writes.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2,
    MV_FIN   = 2'd3
  } mv_state_e;

  // One pointer step; callers keep the low bits they need (wrap is natural)
  function automatic logic [31:0] step_val(input logic [31:0] v, input logic down);
    return down ? (v - 32'd1) : (v + 32'd1);
  endfunction

endpackage

// File: rtl/blkmove_stepreg.sv
module blkmove_stepreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         step_i,
  input  logic         down_i,
  output logic [W-1:0] q_o
);
  import blkmove_pkg::*;

  logic [31:0] nxt_wide;
  logic [W-1:0] q;

  always_comb nxt_wide = step_val(32'(q), down_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (load_i) q <= ld_val_i;
    else if (step_i) q <= nxt_wide[W-1:0];
  end

  assign q_o = q;
endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cnt_zero_i,
  input  logic last_i,
  output logic accept_o,
  output logic elem_done_o,
  output logic rd_o,
  output logic wr_o,
  output logic busy_o,
  output logic done_o
);
  import blkmove_pkg::*;

  mv_state_e st, st_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= MV_IDLE;
    else        st <= st_nxt;
  end

  always_comb begin
    st_nxt = st;
    case (st)
      MV_IDLE:  if (start_i) st_nxt = cnt_zero_i ? MV_FIN : MV_READ;
      MV_READ:  st_nxt = MV_WRITE;
      MV_WRITE: st_nxt = last_i ? MV_FIN : MV_READ;
      default:  st_nxt = MV_IDLE;
    endcase
  end

  assign accept_o    = (st == MV_IDLE) && start_i;
  assign elem_done_o = (st == MV_WRITE);
  assign rd_o        = (st == MV_READ);
  assign wr_o        = (st == MV_WRITE);
  assign busy_o      = (st != MV_IDLE);
  assign done_o      = (st == MV_FIN);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o)); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> wr_o); // R2
  AST_ZERO_NOACC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && cnt_zero_i) |=> (done_o && !rd_o && !wr_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R8
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dir_down_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] src_ptr_o,
  output logic [AW-1:0] dst_ptr_o,
  output logic [CW-1:0] cnt_o
);
  import blkmove_pkg::*;

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  // named internal events
  logic accept, elem_done, cnt_zero_ld, last_elem, dir_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;

  assign cnt_zero_ld = (cnt_i == '0);
  assign last_elem   = (cnt_q == CNT_ONE);

  blkmove_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cnt_zero_i(cnt_zero_ld), .last_i(last_elem),
    .accept_o(accept), .elem_done_o(elem_done),
    .rd_o(mem_rd_o), .wr_o(mem_wr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (accept) dir_q <= dir_down_i;
  end

  blkmove_stepreg #(.W(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .ld_val_i(src_i),
    .step_i(elem_done), .down_i(dir_q), .q_o(src_q)
  );

  blkmove_stepreg #(.W(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .ld_val_i(dst_i),
    .step_i(elem_done), .down_i(dir_q), .q_o(dst_q)
  );

  blkmove_stepreg #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .ld_val_i(cnt_i),
    .step_i(elem_done), .down_i(1'b1), .q_o(cnt_q)
  );

  assign mem_addr_o  = mem_wr_o ? dst_q : src_q;
  assign mem_wdata_o = mem_rdata_i;
  assign src_ptr_o   = src_q;
  assign dst_ptr_o   = dst_q;
  assign cnt_o       = cnt_q;

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R3
  AST_DONE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == '0)); // R3
  AST_PTRS_MOVE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> ((src_q - $past(src_q)) == (dst_q - $past(dst_q)))); // R4
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> ($stable(dir_q) && busy_o)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q))); // R9
endmodule

// File: tb/blkmove_engine_bench.sv
module blkmove_engine_bench;
  localparam int AW = 8, DW = 16, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, dir_down_i = 1'b0;
  logic [AW-1:0] src_i = '0, dst_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic [AW-1:0] mem_addr_o, src_ptr_o, dst_ptr_o;
  logic mem_rd_o, mem_wr_o, busy_o, done_o;
  logic [DW-1:0] mem_rdata_i = '0, mem_wdata_o;
  logic [CW-1:0] cnt_o;

  always #10 clk = ~clk;  // 50 MHz

  blkmove_engine #(.AW(AW), .DW(DW), .CW(CW)) u_blkmove_engine (.*);

  // memory model and bench shadow copy
  logic [DW-1:0] mem [256];
  logic [DW-1:0] sh  [256];
  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  int n_tests = 0, n_fail = 0, n_wr_seen = 0, n_acc = 0, cyc = 0;
  logic [AW-1:0] rdq [$];
  logic [AW+DW-1:0] wrq [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected reads and writes as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_o) begin
        n_acc++;
        if (rdq.size() == 0) chk(0, "R2", "unexpected read addr", mem_addr_o, 0);
        else begin
          logic [AW-1:0] e;
          e = rdq.pop_front();
          chk(mem_addr_o == e, "R2", "read addr", mem_addr_o, e);
        end
      end
      if (mem_wr_o) begin
        n_acc++;
        n_wr_seen++;
        if (wrq.size() == 0) chk(0, "R2", "unexpected write addr", mem_addr_o, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = wrq.pop_front();
          chk({mem_addr_o, mem_wdata_o} == e, "R2", "write addr/data",
              {mem_addr_o, mem_wdata_o}, e);
        end
      end
    end
  end

  function automatic logic [AW-1:0] nudge(input logic [AW-1:0] p, input bit dn);
    logic [AW:0] t;
    t = dn ? ({1'b0, p} + {1'b0, {AW{1'b1}}}) : ({1'b0, p} + 1);
    return t[AW-1:0];
  endfunction

  // driver: pushes expectations, then runs one transfer
  task automatic run_copy(input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input int n, input bit dn, input bit poke,
                          input string tag);
    logic [AW-1:0] ss, dd;
    int k, wbase, abase;
    ss = s; dd = d;
    for (int i = 0; i < n; i++) begin
      rdq.push_back(ss);
      wrq.push_back({dd, sh[ss]});
      sh[dd] = sh[ss];
      ss = nudge(ss, dn);
      dd = nudge(dd, dn);
    end
    wbase = n_wr_seen; abase = n_acc;
    @(negedge clk);
    src_i = s; dst_i = d; cnt_i = CW'(n); dir_down_i = dn; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", "busy after accept", busy_o, 1);
    k = 0;
    while (!done_o && k < 2000) begin
      @(negedge clk);
      k++;
      if (poke && k == 1) begin      // R10: start while busy
        src_i = 8'h77; dst_i = 8'h99; cnt_i = 8'd3; dir_down_i = ~dn; start_i = 1'b1;
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    chk(k == 2 * n, (n == 0) ? "R7" : "R8", "cycles to done", k, 2 * n);
    chk(busy_o == 1'b1, "R8", "busy during done", busy_o, 1);
    chk(src_ptr_o == ss, tag, "final src ptr", src_ptr_o, ss);
    chk(dst_ptr_o == dd, tag, "final dst ptr", dst_ptr_o, dd);
    chk(cnt_o == '0, "R3", "final count", cnt_o, 0);
    chk(n_wr_seen - wbase == n, poke ? "R10" : "R3", "write count", n_wr_seen - wbase, n);
    if (n == 0) chk(n_acc == abase, "R7", "accesses on zero count", n_acc - abase, 0);
    chk(rdq.size() == 0 && wrq.size() == 0, "R2", "pending expectations",
        rdq.size() + wrq.size(), 0);
    @(negedge clk);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "done pulse ended", {busy_o, done_o}, 0);
    chk(src_ptr_o == ss && dst_ptr_o == dd, "R9", "pointers held idle",
        {src_ptr_o, dst_ptr_o}, {ss, dd});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = DW'(i * 37 + 5) ^ 16'hA000;
      sh[i]  = DW'(i * 37 + 5) ^ 16'hA000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_rd_o && !mem_wr_o, "R1", "idle after reset",
        {busy_o, done_o, mem_rd_o, mem_wr_o}, 0);
    chk(cnt_o == 0 && src_ptr_o == 0 && dst_ptr_o == 0, "R1", "regs after reset",
        {cnt_o, src_ptr_o, dst_ptr_o}, 0);
    run_copy(8'h10, 8'h40, 5, 1'b0, 1'b0, "R4");
    run_copy(8'h30, 8'h80, 6, 1'b1, 1'b0, "R5");
    run_copy(8'h20, 8'h50, 0, 1'b0, 1'b0, "R7");
    run_copy(8'hFD, 8'h60, 5, 1'b0, 1'b0, "R6");
    run_copy(8'h02, 8'hC0, 5, 1'b1, 1'b0, "R6");
    run_copy(8'h0A, 8'h0C, 6, 1'b1, 1'b0, "R5");
    run_copy(8'hA0, 8'hB0, 4, 1'b0, 1'b1, "R10");
    run_copy(8'h00, 8'h01, 1, 1'b0, 1'b0, "R4");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "R8", "watchdog expired", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule